// File: doc/BRIEF.md
# Likely-Branch Resolution Unit

This unit settles "likely" conditional branches for a 32-bit five-stage RISC pipeline. Each cycle it receives a decoded branch kind, two register operands, a 16-bit immediate offset, the address of the delay-slot instruction and a condition flag from coprocessor 0. From these it produces five results: a taken flag, the branch target, an annul request that squashes the delay-slot instruction when the branch falls through, and a link write-enable with the return address.

A likely branch differs from an ordinary delayed branch in one way. When the condition fails, the delay-slot instruction is discarded instead of executed. The two link forms write the return address whether or not the branch is taken.

The decision, the target and the link value are combinational, so they are ready in the resolving stage. The annul request is also registered for one cycle, so the following stage can cancel the delay slot. While the pipeline is stalled, the registered copy is held low, so a delay slot that sits in place for several cycles is cancelled only once.

Top module: `likely_branch_unit`

## Requirements
- R1: Kind code 1 is taken when `opnd_a == opnd_b`. Kind code 2 is taken when the two operands differ.
- R2: Kind codes 3 to 8 compare `opnd_a`, read as a signed 32-bit value, against zero:
  - 3 is taken when `opnd_a` is less than or equal to zero.
  - 4 is taken when `opnd_a` is greater than zero.
  - 5 and 7 are taken when `opnd_a` is less than zero.
  - 6 and 8 are taken when `opnd_a` is greater than or equal to zero.
  - Kind codes 3 to 8 do not use `opnd_b`.
- R3: Kind code 9 is taken when `cp_cond` is 1. Kind code 10 is taken when `cp_cond` is 0.
- R4: For kind codes 1 to 10, `annul_slot` is the inverse of `br_taken`. The two are never high together.
- R5: `br_target` equals `slot_pc` plus the 16-bit offset, sign-extended to 32 bits and shifted left by two. The sum wraps modulo 2^32.
- R6: For kind codes 7 and 8, `link_we` is 1 whether or not the branch is taken, and `link_addr` equals `slot_pc + 4`, wrapping modulo 2^32. For every other kind code, `link_we` is 0.
- R7: Kind code 0 means "no branch", and codes 11 to 15 are treated the same way. For these codes, `br_taken`, `annul_slot` and `link_we` are all 0.
- R8: `annul_slot_q` is cleared by synchronous active-high `rst`. After a clock edge where `stall` is 0, it equals the `annul_slot` value sampled at that edge. After a clock edge where `stall` is 1, it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Pipeline stall; holds the registered annul low |
| br_kind | input | 4 | Decoded branch kind code (see R1 to R7) |
| opnd_a | input | 32 | First register operand |
| opnd_b | input | 32 | Second register operand |
| offset_imm | input | 16 | Immediate branch offset in words |
| slot_pc | input | 32 | Address of the delay-slot instruction |
| cp_cond | input | 1 | Coprocessor-0 condition flag |
| br_taken | output | 1 | Branch condition met |
| br_target | output | 32 | Branch target address |
| annul_slot | output | 1 | Squash request for the delay slot |
| link_we | output | 1 | Return-address write enable |
| link_addr | output | 32 | Return address (delay slot + 4) |
| annul_slot_q | output | 1 | Annul request registered for the next stage |

## Verification
Almost all of this block is combinational. A wrong condition decode or a wrong target sum therefore shows at `br_taken`, `annul_slot` or `br_target` in the same cycle the kind code is applied. The only state is the registered annul. If it is wrong, `annul_slot_q` differs from the expected value one edge after the branch. That would be either a missed squash or a double squash during a stall. The stimulus sweeps every kind code against the operand values 0, 1, -1, 0x7FFFFFFF and 0x80000000. It also applies offsets of 0x7FFF and 0x8000, and slot addresses near the wrap point.

// File: rtl/lbu_pkg.sv
package lbu_pkg;
  localparam int KIND_W = 4;

  typedef enum logic [KIND_W-1:0] {
    BK_NONE     = 4'd0,
    BK_EQ       = 4'd1,
    BK_NE       = 4'd2,
    BK_LEZ      = 4'd3,
    BK_GTZ      = 4'd4,
    BK_LTZ      = 4'd5,
    BK_GEZ      = 4'd6,
    BK_LTZ_LINK = 4'd7,
    BK_GEZ_LINK = 4'd8,
    BK_CP_TRUE  = 4'd9,
    BK_CP_FALSE = 4'd10
  } br_kind_e;
endpackage

// File: rtl/lbu_cond.sv
module lbu_cond #(
  parameter int XLEN = 32
) (
  input  logic [lbu_pkg::KIND_W-1:0] kind,
  input  logic [XLEN-1:0]            a,
  input  logic [XLEN-1:0]            b,
  input  logic                       cp_flag,
  output logic                       is_branch,
  output logic                       is_link,
  output logic                       cond_true
);
  import lbu_pkg::*;

  logic a_neg, a_zero, a_eq_b;
  br_kind_e k;

  assign k      = br_kind_e'(kind);
  assign a_neg  = a[XLEN-1];
  assign a_zero = (a == '0);
  assign a_eq_b = (a == b);

  always_comb begin
    is_branch = 1'b1;
    is_link   = 1'b0;
    cond_true = 1'b0;
    unique case (k)
      BK_EQ:       cond_true = a_eq_b;
      BK_NE:       cond_true = !a_eq_b;
      BK_LEZ:      cond_true = a_neg || a_zero;
      BK_GTZ:      cond_true = !a_neg && !a_zero;
      BK_LTZ:      cond_true = a_neg;
      BK_GEZ:      cond_true = !a_neg;
      BK_LTZ_LINK: begin cond_true = a_neg;  is_link = 1'b1; end
      BK_GEZ_LINK: begin cond_true = !a_neg; is_link = 1'b1; end
      BK_CP_TRUE:  cond_true = cp_flag;
      BK_CP_FALSE: cond_true = !cp_flag;
      default:     is_branch = 1'b0;
    endcase
  end
endmodule

// File: rtl/lbu_addr.sv
module lbu_addr #(
  parameter int XLEN      = 32,
  parameter int OFF_W     = 16,
  parameter int ALIGN_SH  = 2,
  parameter int LINK_STEP = 4
) (
  input  logic [XLEN-1:0]  base_pc,
  input  logic [OFF_W-1:0] off,
  output logic [XLEN-1:0]  target,
  output logic [XLEN-1:0]  ret_addr
);
  localparam int EXT_W = XLEN - OFF_W;

  logic [XLEN-1:0] off_ext;
  logic [XLEN-1:0] off_scaled;

  assign off_ext    = {{EXT_W{off[OFF_W-1]}}, off};
  assign off_scaled = off_ext << ALIGN_SH;
  assign target     = base_pc + off_scaled;
  assign ret_addr   = base_pc + XLEN'(LINK_STEP);
endmodule

// File: rtl/lbu_annul_reg.sv
module lbu_annul_reg (
  input  logic clk,
  input  logic rst,
  input  logic stall,
  input  logic annul_in,
  output logic annul_q
);
  always_ff @(posedge clk) begin
    if (rst)        annul_q <= 1'b0;
    else if (stall) annul_q <= 1'b0;
    else            annul_q <= annul_in;
  end
endmodule

// File: rtl/likely_branch_unit.sv
module likely_branch_unit #(
  parameter int XLEN      = 32,
  parameter int OFF_W     = 16,
  parameter int ALIGN_SH  = 2,
  parameter int LINK_STEP = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       stall,
  input  logic [lbu_pkg::KIND_W-1:0] br_kind,
  input  logic [XLEN-1:0]            opnd_a,
  input  logic [XLEN-1:0]            opnd_b,
  input  logic [OFF_W-1:0]           offset_imm,
  input  logic [XLEN-1:0]            slot_pc,
  input  logic                       cp_cond,
  output logic                       br_taken,
  output logic [XLEN-1:0]            br_target,
  output logic                       annul_slot,
  output logic                       link_we,
  output logic [XLEN-1:0]            link_addr,
  output logic                       annul_slot_q
);
  logic is_br, is_lnk, cond_ok;

  lbu_cond #(.XLEN(XLEN)) u_cond (
    .kind      (br_kind),
    .a         (opnd_a),
    .b         (opnd_b),
    .cp_flag   (cp_cond),
    .is_branch (is_br),
    .is_link   (is_lnk),
    .cond_true (cond_ok)
  );

  lbu_addr #(
    .XLEN(XLEN), .OFF_W(OFF_W), .ALIGN_SH(ALIGN_SH), .LINK_STEP(LINK_STEP)
  ) u_addr (
    .base_pc  (slot_pc),
    .off      (offset_imm),
    .target   (br_target),
    .ret_addr (link_addr)
  );

  assign br_taken   = is_br && cond_ok;
  assign annul_slot = is_br && !cond_ok;
  assign link_we    = is_lnk;

  lbu_annul_reg u_annul (
    .clk      (clk),
    .rst      (rst),
    .stall    (stall),
    .annul_in (annul_slot),
    .annul_q  (annul_slot_q)
  );
endmodule

// File: rtl/lbu_checker.sv
module lbu_checker #(
  parameter int XLEN      = 32,
  parameter int OFF_W     = 16,
  parameter int ALIGN_SH  = 2,
  parameter int LINK_STEP = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       stall,
  input logic [lbu_pkg::KIND_W-1:0] br_kind,
  input logic [XLEN-1:0]            opnd_a,
  input logic [XLEN-1:0]            opnd_b,
  input logic [OFF_W-1:0]           offset_imm,
  input logic [XLEN-1:0]            slot_pc,
  input logic                       cp_cond,
  input logic                       br_taken,
  input logic [XLEN-1:0]            br_target,
  input logic                       annul_slot,
  input logic                       link_we,
  input logic [XLEN-1:0]            link_addr,
  input logic                       annul_slot_q
);
  p_eq_taken_r1: assert property (@(posedge clk) disable iff (rst)
    (br_kind == 4'd1 && opnd_a == opnd_b) |-> br_taken);

  p_ltz_sign_r2: assert property (@(posedge clk) disable iff (rst)
    (br_kind == 4'd5) |-> (br_taken == opnd_a[XLEN-1]));

  p_cp_false_r3: assert property (@(posedge clk) disable iff (rst)
    (br_kind == 4'd10 && cp_cond) |-> !br_taken);

  p_annul_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(annul_slot && br_taken));

  p_wrap_target_r5: assert property (@(posedge clk) disable iff (rst)
    (offset_imm == '0) |-> (br_target == slot_pc));

  p_link_value_r6: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (link_addr == slot_pc + XLEN'(LINK_STEP)));

  p_none_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (br_kind == 4'd0) |-> (!br_taken && !annul_slot && !link_we));

  p_annul_capture_r8: assert property (@(posedge clk) disable iff (rst)
    (annul_slot && !stall) |=> annul_slot_q);

  p_stall_block_r8: assert property (@(posedge clk) disable iff (rst)
    stall |=> !annul_slot_q);

  logic unused_ok;
  assign unused_ok = &{1'b0, opnd_b[0], ALIGN_SH[0]};
endmodule

bind likely_branch_unit lbu_checker #(
  .XLEN(XLEN), .OFF_W(OFF_W), .ALIGN_SH(ALIGN_SH), .LINK_STEP(LINK_STEP)
) u_chk (.*);

// File: tb/likely_branch_unit_test.sv
module likely_branch_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic [3:0]  br_kind = 4'd0;
  logic [31:0] opnd_a = '0, opnd_b = '0, slot_pc = '0;
  logic [15:0] offset_imm = '0;
  logic        cp_cond = 1'b0;
  logic        br_taken, annul_slot, link_we, annul_slot_q;
  logic [31:0] br_target, link_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  likely_branch_unit uut (.*);

  typedef struct {
    logic [3:0]  kind;
    logic        stl;
    logic        tk, an, lw;
    logic [31:0] tgt, lnk;
  } exp_t;

  exp_t sb[$];

  function automatic string req_of(logic [3:0] k);
    if (k == 4'd1 || k == 4'd2) return "R1";
    if (k >= 4'd3 && k <= 4'd8) return "R2";
    if (k == 4'd9 || k == 4'd10) return "R3";
    return "R7";
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] k, logic [31:0] a, logic [31:0] b,
                       logic [15:0] off, logic [31:0] pc, logic cp, logic st);
    exp_t e;
    logic c, br;
    @(negedge clk);
    br_kind = k; opnd_a = a; opnd_b = b; offset_imm = off;
    slot_pc = pc; cp_cond = cp; stall = st;
    case (k)
      4'd1: c = (a == b);
      4'd2: c = (a != b);
      4'd3: c = ($signed(a) <= 0);
      4'd4: c = ($signed(a) > 0);
      4'd5, 4'd7: c = ($signed(a) < 0);
      4'd6, 4'd8: c = ($signed(a) >= 0);
      4'd9:  c = cp;
      4'd10: c = !cp;
      default: c = 1'b0;
    endcase
    br = (k >= 4'd1 && k <= 4'd10);
    e.kind = k; e.stl = st;
    e.tk = br && c;
    e.an = br && !c;
    e.lw = (k == 4'd7 || k == 4'd8);
    e.tgt = pc + ({{16{off[15]}}, off} << 2);
    e.lnk = pc + 32'd4;
    sb.push_back(e);
  endtask

  // monitor: outputs sampled 1 ns after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst && sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(req_of(e.kind), "br_taken", 32'(br_taken), 32'(e.tk));
        chk((e.kind >= 4'd1 && e.kind <= 4'd10) ? "R4" : "R7", "annul_slot",
            32'(annul_slot), 32'(e.an));
        chk("R6", "link_we", 32'(link_we), 32'(e.lw));
        if (e.lw) chk("R6", "link_addr", link_addr, e.lnk);
        if (e.kind != 4'd0) chk("R5", "br_target", br_target, e.tgt);
        chk("R8", "annul_slot_q", 32'(annul_slot_q), e.stl ? 32'd0 : 32'(e.an));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] vals [5];
    logic [31:0] pcs  [5];
    logic [15:0] offs [3];
    vals = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000};
    pcs  = '{32'h0000_1000, 32'hFFFF_FFFC, 32'h8000_0000, 32'h0, 32'h7FFF_FFFC};
    offs = '{16'h7FFF, 16'h8000, 16'h0001};

    // reset: register stays clear even with a not-taken branch applied (R8)
    @(negedge clk);
    br_kind = 4'd1; opnd_a = 32'd1; opnd_b = 32'd2;
    repeat (3) @(posedge clk);
    #1 chk("R8", "annul_slot_q in reset", 32'(annul_slot_q), 32'd0);
    @(negedge clk);
    rst = 1'b0;
    br_kind = 4'd0;
    @(posedge clk);
    #1 chk("R8", "annul_slot_q after reset", 32'(annul_slot_q), 32'd0);

    // sweep all branch kinds over boundary operands
    for (int k = 1; k <= 10; k++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          drive(4'(k), vals[i], vals[j], offs[(i + j) % 3], pcs[j],
                1'((i + j) & 1), ((i * 5 + j) % 4) == 3);

    // no-branch codes, including unused ones (R7)
    for (int k = 11; k <= 15; k++)
      drive(4'(k), 32'h1, 32'h2, 16'h8000, 32'h100, 1'b1, 1'b0);
    drive(4'd0, 32'h5, 32'h5, 16'h7FFF, 32'h40, 1'b0, 1'b0);

    // stalled not-taken branch held, then released: squashed once (R8)
    drive(4'd2, 32'h9, 32'h9, 16'h0, 32'h200, 1'b0, 1'b1);
    drive(4'd2, 32'h9, 32'h9, 16'h0, 32'h200, 1'b0, 1'b1);
    drive(4'd2, 32'h9, 32'h9, 16'h0, 32'h200, 1'b0, 1'b0);
    drive(4'd0, 32'h0, 32'h0, 16'h0, 32'h204, 1'b0, 1'b0);

    @(negedge clk);
    br_kind = 4'd0; stall = 1'b0;
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule